// File: doc/BRIEF.md
# Asynchronous SRAM Timing Monitor

This block watches the pins of a 512K x 16 asynchronous static RAM port. It samples them on a fast clock and measures each interval as a count of samples. It does not model the memory contents. On every sample it tests the minimum timing rules for read and write cycles. When a rule is broken it sets a sticky flag and records a code for the first rule that failed. It also counts completed read cycles and completed write cycles. The monitor is meant to sit beside a memory controller in a chip, or in a prototype, as a permanent on-line checker.

A write window is open while the chip is selected (chip enable low and second select high), write enable is low and at least one byte enable is low. When the window closes, the monitor looks back from the sample where it closed and checks five things: how long the window lasted, how long the chip had been selected, how long the address had been steady, how long the controller had driven the data bus, and, for a write that the byte enables ended, how long the byte enables had been low. Two further rules apply at any time. The first is the minimum time an address must stay in place while the chip is selected. The second forbids driving the bus while the memory drives it.

Each threshold is given in nanoseconds and converted to samples, rounded up. The sample period is a parameter. With the default period of 4 ns the thresholds are 13 samples (write pulse), 15 (selected to write end), 15 (address setup), 8 (data setup), 15 (byte enables to write end) and 18 (address stability).

Top module: `sram_timing_monitor`

## Requirements
- R1: After a synchronous active-low reset, err_flags is 0, err_code is 0 and both cycle counters are 0.
- R2: A write window exists only while ce_n=0, cs2=1, we_n=0 and bhe_n or ble_n is 0. wr_count increments once, one sample after the first sample in which the window is closed. Activity with cs2=0 is neither counted nor checked.
- R3: If the closed window lasted fewer than PWE samples, err_flags bit 0 is set (code 1).
- R4: If the chip had been continuously selected for fewer than SCE samples before the write end, bit 1 is set (code 2).
- R5: If the address had been unchanged for fewer than AW samples before the write end, bit 2 is set (code 3).
- R6: If drv had been continuously high for fewer than SD samples before the write end, bit 3 is set (code 4).
- R7: A write ended by the byte enables (chip still selected and we_n still 0 in the ending sample) in which the byte enables had been low for fewer than BW samples sets bit 4 (code 5). The same short byte-enable time has no effect when chip enable or write enable ends the write.
- R8: If the address changes while the chip was selected in both the previous and the current sample, and the old address had been held, counted within the selection, for fewer than RC samples, bit 5 is set (code 6). An address change while the chip is deselected never sets a flag.
- R9: If drv=1 while the chip is selected, oe_n=0 and we_n=1, bit 6 is set (code 7). The same drive with oe_n=1 or with the chip deselected has no effect.
- R10: Flags stay set until clr. err_code holds the code of the first violation seen since the last clear. When several violations occur in the same sample, the lowest code wins. clr returns both outputs to 0.
- R11: rd_count increments when a read cycle (selected, we_n=1, oe_n=0, a byte enable low) ends, either because the read condition drops or because the address changes during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears the sticky flags and the first-violation code |
| ce_n | input | 1 | Sampled chip enable, active low |
| cs2 | input | 1 | Sampled second chip select, active high |
| we_n | input | 1 | Sampled write enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| bhe_n | input | 1 | Sampled upper byte enable, active low |
| ble_n | input | 1 | Sampled lower byte enable, active low |
| addr | input | ADDR_W | Sampled address pins |
| drv | input | 1 | High while the controller drives the data bus |
| err_flags | output | 7 | Sticky per-rule violation flags (bit n is code n+1) |
| err_code | output | 3 | Code of the first violation since the last clear, 0 if none |
| rd_count | output | CNT_W | Completed read cycles, wrapping |
| wr_count | output | CNT_W | Completed write windows, wrapping |

## Verification
Writes are run in all three ending styles. Each measured interval is placed one sample below its threshold and then exactly at it, while every other interval is kept well clear. This shows that each rule trips at its own boundary and on no neighbouring rule. The byte-enable interval is also kept short in a write that write enable ends, which shows that rule R7 applies only to writes the byte enables end. Reads hold an address for lengths around the stability threshold, with address changes made while deselected mixed in, and bus drive is tried with each of the qualifying conditions removed in turn. A write with two simultaneous faults, followed by a later fault, separates the first-code priority from the sticky accumulation.

// File: rtl/sram_mon_pkg.sv
// Package: shared constants and helpers for the SRAM timing monitor.
// Assumes every rule index maps to code index+1 on err_code.
package sram_mon_pkg;
    localparam int NUM_RULES = 7;

    // bit positions of the per-rule hit vector (code = position + 1)
    localparam int HIT_PULSE  = 0;
    localparam int HIT_SELECT = 1;
    localparam int HIT_ASETUP = 2;
    localparam int HIT_DSETUP = 3;
    localparam int HIT_BYTEEN = 4;
    localparam int HIT_ASTAB  = 5;
    localparam int HIT_FIGHT  = 6;

    // nanoseconds to samples, rounded up
    function automatic int ns_to_samples(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction
endpackage

// File: rtl/sm_run_counter.sv
// Module: counts consecutive samples in which cond was high, saturating.
// Assumes: the value at a sample covers samples up to the previous one only.
module sm_run_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cond,
    output logic [W-1:0] cnt
);
    // Purpose: restart on a low sample, otherwise count up to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!cond)      cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    // R3
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> cnt == '0);
    // R3
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && cnt != '1) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/sm_addr_age.sv
// Module: tracks how long the current address has stayed unchanged.
// Assumes: after reset the age is saturated, so a start-up address counts as old.
module sm_addr_age #(
    parameter int ADDR_W = 19,
    parameter int W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              changed,
    output logic [W-1:0]      age
);
    logic [ADDR_W-1:0] addr_q;

    // Purpose: flag a difference from the previous sample.
    always_comb changed = (addr != addr_q);

    // Purpose: remember the address and restart the age when it moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            age    <= '1;
        end else begin
            addr_q <= addr;
            if (changed)        age <= W'(1);
            else if (age != '1) age <= age + 1'b1;
        end
    end

    // R5
    age_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> age == W'(1));
endmodule

// File: rtl/sm_err_latch.sv
// Module: sticky per-rule flags plus the code of the first violation.
// Assumes: clear and new hits in one sample keep the new hits.
module sm_err_latch #(
    parameter int N      = 7,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [N-1:0]      hits,
    output logic [N-1:0]      flags_q,
    output logic [CODE_W-1:0] code_q
);
    logic [CODE_W-1:0] first_hit;
    logic [N-1:0]      flags_base;
    logic [CODE_W-1:0] code_base;

    // Purpose: lowest-numbered rule among simultaneous hits.
    always_comb begin
        first_hit = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) first_hit = CODE_W'(i + 1);
        end
    end

    // Purpose: the state left after an optional clear.
    always_comb begin
        flags_base = clr ? '0 : flags_q;
        code_base  = clr ? '0 : code_q;
    end

    // Purpose: accumulate flags and keep the first code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            code_q  <= '0;
        end else begin
            flags_q <= flags_base | hits;
            code_q  <= (code_base != '0) ? code_base : first_hit;
        end
    end

    // R10
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R10
    first_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0 && !clr) |=> code_q == $past(code_q));
    // R10
    code_flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0) == (flags_q == '0));
    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hits == '0) |=> (flags_q == '0 && code_q == '0));
endmodule

// File: rtl/sram_timing_monitor.sv
// Module: timing-rule monitor for a 512K x 16 asynchronous SRAM port.
// Assumes: pins are already synchronised to clk. Thresholds are in samples,
// rounded up from nanosecond minimums. Memory contents are not modelled.
module sram_timing_monitor
    import sram_mon_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int CNT_W     = 16,
    parameter int SAMPLE_NS = 4,
    parameter int PWE_NS    = 50,
    parameter int SCE_NS    = 60,
    parameter int AW_NS     = 60,
    parameter int SD_NS     = 30,
    parameter int BW_NS     = 60,
    parameter int RC_NS     = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ce_n,
    input  logic              cs2,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              bhe_n,
    input  logic              ble_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              drv,
    output logic [6:0]        err_flags,
    output logic [2:0]        err_code,
    output logic [CNT_W-1:0]  rd_count,
    output logic [CNT_W-1:0]  wr_count
);
    localparam int PWE_S = ns_to_samples(PWE_NS, SAMPLE_NS);
    localparam int SCE_S = ns_to_samples(SCE_NS, SAMPLE_NS);
    localparam int AW_S  = ns_to_samples(AW_NS, SAMPLE_NS);
    localparam int SD_S  = ns_to_samples(SD_NS, SAMPLE_NS);
    localparam int BW_S  = ns_to_samples(BW_NS, SAMPLE_NS);
    localparam int RC_S  = ns_to_samples(RC_NS, SAMPLE_NS);
    localparam int MAX_A = (PWE_S > SCE_S) ? PWE_S : SCE_S;
    localparam int MAX_B = (AW_S > BW_S) ? AW_S : BW_S;
    localparam int MAX_C = (SD_S > RC_S) ? SD_S : RC_S;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_S = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int RUN_W = $clog2(MAX_S + 2) + 1;
    localparam logic [RUN_W-1:0] PWE_L = RUN_W'(PWE_S);
    localparam logic [RUN_W-1:0] SCE_L = RUN_W'(SCE_S);
    localparam logic [RUN_W-1:0] AW_L  = RUN_W'(AW_S);
    localparam logic [RUN_W-1:0] SD_L  = RUN_W'(SD_S);
    localparam logic [RUN_W-1:0] BW_L  = RUN_W'(BW_S);
    localparam logic [RUN_W-1:0] RC_L  = RUN_W'(RC_S);

    localparam int NRUN   = 4;
    localparam int IX_WIN = 0;
    localparam int IX_SEL = 1;
    localparam int IX_DRV = 2;
    localparam int IX_BE  = 3;

    logic                 selected, be_any, wr_open, rd_open;
    logic                 wr_open_q, sel_q, rd_open_q;
    logic                 wr_end, be_end, rd_end;
    logic [NRUN-1:0]      run_cond;
    logic [RUN_W-1:0]     run_cnt [NRUN];
    logic                 addr_moved;
    logic [RUN_W-1:0]     addr_age, held_sel;
    logic [NUM_RULES-1:0] hits;

    // Purpose: decode the pin state of the current sample.
    always_comb begin
        selected = !ce_n && cs2;
        be_any   = !bhe_n || !ble_n;
        wr_open  = selected && !we_n && be_any;
        rd_open  = selected && we_n && !oe_n && be_any;
        run_cond = '0;
        run_cond[IX_WIN] = wr_open;
        run_cond[IX_SEL] = selected;
        run_cond[IX_DRV] = drv;
        run_cond[IX_BE]  = be_any;
    end

    // one run-length counter per measured interval
    for (genvar g = 0; g < NRUN; g++) begin : g_run
        sm_run_counter #(.W(RUN_W)) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (run_cond[g]),
            .cnt   (run_cnt[g])
        );
    end

    sm_addr_age #(.ADDR_W(ADDR_W), .W(RUN_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .changed (addr_moved),
        .age     (addr_age)
    );

    // Purpose: previous-sample copies of the window and selection state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open_q <= 1'b0;
            sel_q     <= 1'b0;
            rd_open_q <= 1'b0;
        end else begin
            wr_open_q <= wr_open;
            sel_q     <= selected;
            rd_open_q <= rd_open;
        end
    end

    // Purpose: cycle-end events and the address hold counted inside selection.
    always_comb begin
        wr_end   = wr_open_q && !wr_open;
        be_end   = wr_end && selected && !we_n && !be_any;
        rd_end   = rd_open_q && (!rd_open || addr_moved);
        held_sel = (addr_age < run_cnt[IX_SEL]) ? addr_age : run_cnt[IX_SEL];
    end

    // Purpose: evaluate every timing rule on this sample.
    always_comb begin
        hits             = '0;
        hits[HIT_PULSE]  = wr_end && (run_cnt[IX_WIN] < PWE_L);
        hits[HIT_SELECT] = wr_end && (run_cnt[IX_SEL] < SCE_L);
        hits[HIT_ASETUP] = wr_end && (addr_age < AW_L);
        hits[HIT_DSETUP] = wr_end && (run_cnt[IX_DRV] < SD_L);
        hits[HIT_BYTEEN] = be_end && (run_cnt[IX_BE] < BW_L);
        hits[HIT_ASTAB]  = selected && sel_q && addr_moved && (held_sel < RC_L);
        hits[HIT_FIGHT]  = selected && !oe_n && we_n && drv;
    end

    sm_err_latch #(.N(NUM_RULES), .CODE_W(3)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .hits    (hits),
        .flags_q (err_flags),
        .code_q  (err_code)
    );

    // Purpose: completed-cycle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_count <= '0;
            wr_count <= '0;
        end else begin
            if (rd_end) rd_count <= rd_count + 1'b1;
            if (wr_end) wr_count <= wr_count + 1'b1;
        end
    end

    // R2
    wr_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> wr_count == $past(wr_count) + 1'b1);
    // R2
    wr_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_end |=> $stable(wr_count));
    // R11
    rd_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_end |=> $stable(rd_count));
    // R10
    new_hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hits != '0 |=> (err_flags & $past(hits)) == $past(hits));
endmodule

// File: tb/tb_sram_timing_monitor.sv
module tb_sram_timing_monitor;
    localparam int SMP = 4;
    localparam int PWE = (50 + SMP - 1) / SMP;
    localparam int SCE = (60 + SMP - 1) / SMP;
    localparam int AWS = (60 + SMP - 1) / SMP;
    localparam int SDS = (30 + SMP - 1) / SMP;
    localparam int BWS = (60 + SMP - 1) / SMP;
    localparam int RCS = (70 + SMP - 1) / SMP;

    logic        clk = 1'b0;
    logic        rst_n, clr, ce_n, cs2, we_n, oe_n, bhe_n, ble_n, drv;
    logic [18:0] addr;
    logic [6:0]  err_flags;
    logic [2:0]  err_code;
    logic [15:0] rd_count, wr_count;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [6:0]  exp_flags = '0;
    logic [2:0]  exp_code = '0;
    logic [18:0] cur_addr = '0;

    sram_timing_monitor dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ce_n(ce_n), .cs2(cs2),
        .we_n(we_n), .oe_n(oe_n), .bhe_n(bhe_n), .ble_n(ble_n),
        .addr(addr), .drv(drv), .err_flags(err_flags), .err_code(err_code),
        .rd_count(rd_count), .wr_count(wr_count)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ce_n = 1'b1; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        bhe_n = 1'b1; ble_n = 1'b1; drv = 1'b0; clr = 1'b0;
        addr = cur_addr;
    endtask

    // model of the sticky flags and first code
    task automatic model_hits(input logic [6:0] h);
        exp_flags |= h;
        if (exp_code == 3'd0) begin
            for (int i = 6; i >= 0; i--) if (h[i]) exp_code = 3'(i + 1);
        end
    endtask

    task automatic do_clear(input string req);
        clr = 1'b1; tick(); clr = 1'b0; tick();
        exp_flags = '0; exp_code = '0;
        check({req, " clear flags"}, 32'(err_flags), 32'(0));
        check({req, " clear code"}, 32'(err_code), 32'(0));
    endtask

    task automatic check_state(input string req);
        check({req, " flags"}, 32'(err_flags), 32'(exp_flags));
        check({req, " code"}, 32'(err_code), 32'(exp_code));
    endtask

    // mode 0: chip enable ends, 1: write enable ends, 2: byte enables end
    task automatic do_write(input int ce_pre, input int we_pre, input int be_pre,
                            input int d_pre, input int a_pre, input int mode,
                            input logic sel2, input string req);
        int L;
        int win;
        logic [6:0] h;
        logic [15:0] wr0;
        L = ce_pre;
        if (we_pre > L) L = we_pre;
        if (be_pre > L) L = be_pre;
        if (d_pre > L) L = d_pre;
        if (a_pre > L) L = a_pre;
        wr0 = wr_count;
        for (int i = -L - 2; i <= 1; i++) begin
            ce_n  = !((i >= -ce_pre && i < 0) || (i == 0 && mode != 0));
            we_n  = !((i >= -we_pre && i < 0) || (i == 0 && mode != 1));
            bhe_n = !((i >= -be_pre && i < 0) || (i == 0 && mode != 2));
            ble_n = bhe_n;
            drv   = (i >= -d_pre && i <= 0);
            cs2   = sel2;
            oe_n  = 1'b1;
            if (i == -a_pre) cur_addr = cur_addr + 19'd1;
            addr  = cur_addr;
            if (i == 1) go_idle();
            tick();
        end
        go_idle();
        repeat (3) tick();
        win = ce_pre;
        if (we_pre < win) win = we_pre;
        if (be_pre < win) win = be_pre;
        h = '0;
        if (sel2) begin
            h[0] = (win < PWE);
            h[1] = (ce_pre < SCE);
            h[2] = (a_pre < AWS);
            h[3] = (d_pre < SDS);
            h[4] = (mode == 2) && (be_pre < BWS);
        end
        model_hits(h);
        check_state(req);
        check({req, " write count"}, 32'(wr_count), 32'(wr0 + (sel2 ? 16'd1 : 16'd0)));
    endtask

    // read holding an address for h samples, then changing it inside selection
    task automatic do_stab(input int h, input string req);
        logic [15:0] rd0;
        rd0 = rd_count;
        cur_addr = cur_addr + 19'd7;
        go_idle(); tick();
        for (int i = 0; i < h; i++) begin
            ce_n = 1'b0; oe_n = 1'b0; bhe_n = 1'b0; ble_n = 1'b0; tick();
        end
        cur_addr = cur_addr + 19'd1;
        addr = cur_addr;
        repeat (25) tick();
        go_idle();
        repeat (3) tick();
        model_hits({1'b0, (h < RCS), 5'b0});
        check_state(req);
        check({req, " read count"}, 32'(rd_count), 32'(rd0 + 16'd2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        go_idle();
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 flags", 32'(err_flags), 0);
        check("R1 code", 32'(err_code), 0);
        check("R1 rd_count", 32'(rd_count), 0);
        check("R1 wr_count", 32'(wr_count), 0);

        // R2 clean writes in each ending style
        for (int m = 0; m < 3; m++) begin
            do_write(40, 20, 30, 20, 40, m, 1'b1, "R2 clean write");
        end
        // R2 second select low: no window, nothing counted or flagged
        do_write(40, 5, 30, 2, 40, 1, 1'b0, "R2 cs2 low");

        // R3 pulse width around threshold
        for (int w = PWE - 2; w <= PWE + 1; w++) begin
            do_write(40, w, 30, 20, 40, 1, 1'b1, "R3 pulse");
            do_clear("R3");
        end
        // R4 selection length, chip-enable-ended write
        for (int c = SCE - 1; c <= SCE; c++) begin
            do_write(c, 20, 30, 20, c, 0, 1'b1, "R4 select");
            do_clear("R4");
        end
        // R5 address setup
        for (int a = AWS - 1; a <= AWS; a++) begin
            do_write(40, 20, 30, 20, a, 1, 1'b1, "R5 addr setup");
            do_clear("R5");
        end
        // R6 data setup
        for (int d = SDS - 2; d <= SDS; d++) begin
            do_write(40, 20, 30, d, 40, 1, 1'b1, "R6 data setup");
            do_clear("R6");
        end
        // R7 byte-enable-ended writes
        for (int b = BWS - 1; b <= BWS; b++) begin
            do_write(40, 20, b, 20, 40, 2, 1'b1, "R7 byte enable");
            do_clear("R7");
        end
        // R7 short byte enables with write enable ending: no effect
        do_write(40, 20, BWS - 1, 20, 40, 1, 1'b1, "R7 ignored");

        // R8 address stability in reads, R11 read counting
        for (int hh = RCS - 2; hh <= RCS + 1; hh++) begin
            do_stab(hh, "R8 R11 stability");
            do_clear("R8");
        end
        // R8 address changes while deselected
        for (int k = 0; k < 10; k++) begin
            cur_addr = cur_addr + 19'd3; addr = cur_addr; oe_n = 1'b0; tick();
        end
        go_idle(); repeat (3) tick();
        check_state("R8 deselected");

        // R9 drive qualifiers removed one at a time
        ce_n = 1'b0; oe_n = 1'b1; bhe_n = 1'b0; drv = 1'b1; tick();
        go_idle(); oe_n = 1'b0; drv = 1'b1; tick();
        go_idle(); repeat (3) tick();
        check_state("R9 no fight");
        ce_n = 1'b0; oe_n = 1'b0; bhe_n = 1'b0; drv = 1'b1; tick();
        drv = 1'b0; tick();
        go_idle(); repeat (3) tick();
        model_hits(7'b1000000);
        check_state("R9 fight");
        do_clear("R9");

        // R10 simultaneous faults, then a later one
        do_write(40, 5, 30, 2, 40, 1, 1'b1, "R10 priority");
        ce_n = 1'b0; oe_n = 1'b0; bhe_n = 1'b0; drv = 1'b1; tick();
        go_idle(); repeat (3) tick();
        model_hits(7'b1000000);
        check_state("R10 sticky");
        do_clear("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule